// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Protector

This block guards a 16-bit data word with five check bits and one overall parity bit. The encoder side has no registers. It turns a data word into a 22-bit codeword. Each data bit is given its own 5-bit code of weight two or more, so every data bit feeds at least two of the five checks.

The decoder side takes a received codeword together with a strobe. It recomputes the five checks and compares them with the received ones to form a syndrome. It also recomputes the overall parity of all 22 bits. Correction is tried only when the overall parity fails. When the syndrome then points at a data bit, that bit is flipped. A syndrome of weight one, or a zero syndrome, means a check bit or the overall parity bit is wrong, and the data is passed through unchanged. Any other pattern is reported as uncorrectable. One register stage holds the decoded word and its classification.

Top module: `ham_sec_ded`

## Requirements
- R1: The codeword carries the data in bits 15:0, check bits C1..C5 in bits 16..20 (Ci at bit 15+i), and the overall parity bit in bit 21. Data bits 0..15 take the codes 3, 5, 6, 7, 9, 10, 11, 12, 13, 14, 15, 17, 18, 19, 20, 21 in that order. Ci is the XOR of the data bits whose code has bit i-1 set.
- R2: The overall parity bit makes the XOR of all 22 codeword bits zero.
- R3: out_valid is high exactly in the cycle after a cycle with dec_valid high, and the decoded result appears in that same cycle.
- R4: A received word with no error gives out_data equal to its bits 15:0, with all three flags low.
- R5: A single flipped data bit is restored, and out_corrected is set.
- R6: A single flipped check bit (bits 16..20) leaves the data unaltered and sets out_chk_err only.
- R7: A flip of only the overall parity bit (bit 21) leaves the data unaltered and sets out_chk_err only.
- R8: A nonzero syndrome with passing overall parity (a double error) sets out_double only, and the data is passed through unaltered.
- R9: A failing overall parity with a syndrome of weight two or more that matches no data-bit code sets out_double only, and the data is passed through unaltered.
- R10: After reset, out_valid, out_data and all three flags are zero.
- R11: At most one of out_corrected, out_double and out_chk_err is high at any time.
- R12: In a cycle with dec_valid low, out_data and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_data | input | 16 | Word to encode |
| enc_code | output | 22 | Codeword for enc_data (combinational) |
| dec_valid | input | 1 | Strobe: dec_code holds a word to decode |
| dec_code | input | 22 | Received codeword |
| out_valid | output | 1 | Decoded result valid |
| out_data | output | 16 | Decoded, possibly corrected, data |
| out_corrected | output | 1 | A data bit was flipped back |
| out_double | output | 1 | Uncorrectable pattern detected |
| out_chk_err | output | 1 | Only a check or overall parity bit was wrong |

## Verification
The properties assume that dec_code is stable in every cycle in which dec_valid is high. They compare the registered result with the word seen one cycle earlier, so they take no view of what the word contained. They do not assume how many bits were flipped. They only relate the flags to the number of data bits that change between input and output. The stimulus changes inputs only on the falling clock edge and lowers the strobe between vectors. Error masks flip one, two or three chosen bit positions of a codeword that the bench encodes itself.

// File: rtl/ham_pkg.sv
package ham_pkg;
  localparam int DATA_W = 16;
  localparam int CHK_W  = 5;
  localparam int CODE_W = DATA_W + CHK_W + 1;
  localparam int PM_POS = CODE_W - 1;

  // k-th code of weight >= 2, taken in ascending order
  function automatic logic [CHK_W-1:0] code_of(input int k);
    logic [CHK_W-1:0] r;
    logic [CHK_W-1:0] cv;
    int n;
    r = '0;
    n = 0;
    for (int c = 1; c < (1 << CHK_W); c++) begin
      cv = CHK_W'(c);
      if ($countones(cv) >= 2) begin
        if (n == k) r = cv;
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [CHK_W-1:0] calc_chk(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] p;
    logic [CHK_W-1:0] cd;
    p = '0;
    for (int k = 0; k < DATA_W; k++) begin
      cd = code_of(k);
      for (int i = 0; i < CHK_W; i++)
        if (cd[i]) p[i] = p[i] ^ d[k];
    end
    return p;
  endfunction
endpackage

// File: rtl/ham_encoder.sv
module ham_encoder
  import ham_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  logic [CHK_W-1:0] chk;
  logic             pm;

  always_comb begin
    chk = calc_chk(data);
    pm  = ^{chk, data};
    code = {pm, chk, data};
  end
endmodule

// File: rtl/ham_classify.sv
module ham_classify
  import ham_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [CHK_W-1:0]  syn,
  output logic              pm_fail,
  output logic [DATA_W-1:0] fix_mask,
  output logic              is_corr,
  output logic              is_dbl,
  output logic              is_chk
);
  logic [DATA_W-1:0] rx_data;
  logic [CHK_W-1:0]  rx_chk;
  logic [2:0]        syn_wt;

  assign rx_data = code[DATA_W-1:0];
  assign rx_chk  = code[DATA_W +: CHK_W];
  assign syn     = rx_chk ^ calc_chk(rx_data);
  assign pm_fail = ^code;
  assign syn_wt  = 3'($countones(syn));

  for (genvar k = 0; k < DATA_W; k++) begin : g_loc
    assign fix_mask[k] = pm_fail && (syn == code_of(k));
  end

  assign is_corr = |fix_mask;
  assign is_chk  = pm_fail && (syn_wt <= 3'd1);
  assign is_dbl  = (!pm_fail && (syn != '0)) ||
                   (pm_fail && (syn_wt >= 3'd2) && !is_corr);
endmodule

// File: rtl/ham_sec_ded.sv
module ham_sec_ded
  import ham_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       enc_data,
  output logic [21:0]       enc_code,
  input  logic              dec_valid,
  input  logic [21:0]       dec_code,
  output logic              out_valid,
  output logic [15:0]       out_data,
  output logic              out_corrected,
  output logic              out_double,
  output logic              out_chk_err
);
  logic [CHK_W-1:0]  syn;
  logic              pm_fail;
  logic [DATA_W-1:0] fix_mask;
  logic              is_corr, is_dbl, is_chk;

  ham_encoder u_enc (
    .data (enc_data),
    .code (enc_code)
  );

  ham_classify u_cls (
    .code     (dec_code),
    .syn      (syn),
    .pm_fail  (pm_fail),
    .fix_mask (fix_mask),
    .is_corr  (is_corr),
    .is_dbl   (is_dbl),
    .is_chk   (is_chk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_corrected <= 1'b0;
      out_double    <= 1'b0;
      out_chk_err   <= 1'b0;
    end else begin
      out_valid <= dec_valid;
      if (dec_valid) begin
        out_data      <= dec_code[DATA_W-1:0] ^ fix_mask;
        out_corrected <= is_corr;
        out_double    <= is_dbl;
        out_chk_err   <= is_chk;
      end
    end
  end
endmodule

// File: rtl/ham_sec_ded_chk.sv
module ham_sec_ded_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [21:0] enc_code,
  input logic        dec_valid,
  input logic [21:0] dec_code,
  input logic        out_valid,
  input logic [15:0] out_data,
  input logic        out_corrected,
  input logic        out_double,
  input logic        out_chk_err,
  input logic [4:0]  syn,
  input logic        pm_fail
);
  assert_even_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ^enc_code == 1'b0);

  assert_valid_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> out_valid);

  assert_valid_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> !out_valid);

  assert_clean_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_corrected && !out_double && !out_chk_err)
      |-> out_data == $past(dec_code[15:0]));

  assert_one_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_corrected)
      |-> $countones(out_data ^ $past(dec_code[15:0])) == 1);

  // R6 and R8: neither check-bit faults nor uncorrectable words alter data
  assert_untouched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_chk_err || out_double))
      |-> out_data == $past(dec_code[15:0]));

  assert_pm_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && pm_fail && syn == 5'd0) |=> out_chk_err);

  assert_even_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !pm_fail && syn != 5'd0) |=> out_double);

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_corrected, out_double, out_chk_err}));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> ($stable(out_data) && $stable(out_double)));
endmodule

bind ham_sec_ded ham_sec_ded_chk u_chk (.*);

// File: tb/tb_ham_sec_ded.sv
module tb_ham_sec_ded;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] enc_data = '0;
  logic [21:0] enc_code;
  logic        dec_valid = 1'b0;
  logic [21:0] dec_code = '0;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_corrected, out_double, out_chk_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ham_sec_ded dut (.*);

  // per data bit: which check bits it feeds
  localparam logic [4:0] CODES [16] = '{5'd3, 5'd5, 5'd6, 5'd7, 5'd9, 5'd10,
    5'd11, 5'd12, 5'd13, 5'd14, 5'd15, 5'd17, 5'd18, 5'd19, 5'd20, 5'd21};

  // {data, error mask, expected {corrected, double, chk_err}}
  localparam int NV = 13;
  localparam logic [40:0] VEC [NV] = '{
    {16'hA5C3, 22'h000000, 3'b000},  // R4
    {16'h0000, 22'h000000, 3'b000},  // R4
    {16'hFFFF, 22'h000001, 3'b100},  // R5
    {16'h1234, 22'h000080, 3'b100},  // R5
    {16'h8001, 22'h008000, 3'b100},  // R5
    {16'hBEEF, 22'h010000, 3'b001},  // R6
    {16'h7F00, 22'h100000, 3'b001},  // R6
    {16'h5555, 22'h200000, 3'b001},  // R7
    {16'hC0DE, 22'h000003, 3'b010},  // R8
    {16'h0F0F, 22'h010004, 3'b010},  // R8
    {16'h3C3C, 22'h300000, 3'b010},  // R8
    {16'h9999, 22'h208001, 3'b010},  // R9
    {16'h6A6A, 22'h208100, 3'b010}   // R9
  };

  function automatic logic [21:0] tb_encode(input logic [15:0] d);
    logic [4:0] p = '0;
    for (int i = 0; i < 5; i++)
      for (int k = 0; k < 16; k++)
        if (CODES[k][i]) p[i] ^= d[k];
    return {^{p, d}, p, d};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic decode(input logic [21:0] cw);
    @(negedge clk);
    dec_code  = cw;
    dec_valid = 1'b1;
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [21:0] cw;
    logic [15:0] hold_d;
    repeat (3) @(negedge clk);
    check("R10 reset", {out_valid, out_data, out_corrected, out_double, out_chk_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle", {out_valid, out_corrected, out_double, out_chk_err}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] d;
      logic [21:0] m;
      logic [2:0]  f;
      {d, m, f} = VEC[v];
      enc_data = d;
      #1;
      cw = tb_encode(d);
      check("R1 codeword", 32'(enc_code), 32'(cw));
      check("R2 even word", 32'(^enc_code), 0);
      decode(cw ^ m);
      check("R3 valid", 32'(out_valid), 1);
      check("R4-R9 flags", {out_corrected, out_double, out_chk_err}, 32'(f));
      check("R4-R9 data", 32'(out_data), f[2] ? 32'(d) : 32'(d ^ m[15:0]));
      check("R11 excl", 32'($countones({out_corrected, out_double, out_chk_err}) <= 1), 1);
    end

    // R12: an idle cycle keeps the last result and drops valid
    decode(tb_encode(16'h1357) ^ 22'h000010);
    hold_d = out_data;
    check("R5 fix bit4", 32'(out_data), 32'h1357);
    @(negedge clk);
    dec_code = 22'h3FFFFF;
    @(negedge clk);
    check("R3 valid low", 32'(out_valid), 0);
    check("R12 data held", 32'(out_data), 32'(hold_d));
    check("R12 flag held", 32'(out_corrected), 1);

    // R3: back-to-back strobes
    @(negedge clk);
    dec_code = tb_encode(16'h2468);
    dec_valid = 1'b1;
    @(negedge clk);
    check("R3 b2b first", 32'(out_data), 32'h2468);
    dec_code = tb_encode(16'hFACE) ^ 22'h000400;
    @(negedge clk);
    dec_valid = 1'b0;
    check("R3 b2b second", 32'(out_data), 32'hFACE);
    check("R5 b2b flag", 32'(out_corrected), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule